// File: doc/BRIEF.md
# Slave Byte-Parallel FPGA Configuration Loader

This block configures a downstream FPGA through its byte-wide slave configuration port, reading the bitstream from an external image memory one byte at a time. After a `start` pulse, it raises chip-select and write. It then issues a one-cycle init request and waits a fixed settling time. At the end of that wait it samples the INIT-ready pin. If the device is ready, the block pulls chip-select and write low. It reads a four-byte length header stored most significant byte first, and streams that many payload bytes starting at image offset 16.

Each byte is followed by a minimum idle gap, and BUSY is sampled at the end of that gap. A high BUSY aborts the load and reports the index of the offending byte. After the last byte, DONE is sampled. The result stays on `load_ok`, or on `load_fail` with a two-bit `err_code`, until the next `start`. Both wait times are given in microseconds and converted to cycles from the `CLK_HZ` parameter.

The states are IDLE, INIT, WAIT_INIT, READ_LEN, STREAM, CHECK_DONE, OK and FAIL. The transitions are:
- IDLE goes to INIT on `start`.
- INIT goes to WAIT_INIT unconditionally.
- WAIT_INIT goes to READ_LEN when the timer expires with INIT ready, or to FAIL when it expires with INIT not ready.
- READ_LEN goes to STREAM after four header bytes with a non-zero length, or to CHECK_DONE when the length is zero.
- STREAM goes to FAIL on a high BUSY, or to CHECK_DONE after the last byte.
- CHECK_DONE goes to OK or to FAIL.
- OK and FAIL return to INIT on `start`.

Top module: `cfg_loader`

## Requirements
- R1: Out of reset the block is idle: `cfg_cs_n` and `cfg_wr_n` are 1, and `cfg_strobe`, `cfg_init_req`, `load_ok` and `load_fail` are 0. `err_code` is 0 (none).
- R2: A `start` in IDLE, OK or FAIL produces a one-cycle `cfg_init_req` with `cfg_cs_n`/`cfg_wr_n` high. `cfg_init_ok` is sampled INIT_CYC = CLK_HZ/1e6 x INIT_WAIT_US cycles after that pulse. If it is low at that sample, the load ends in FAIL with `err_code` = 1, and no byte is written.
- R3: The payload length is image bytes 0, 1, 2 and 3 taken as a big-endian 32-bit value (byte 0 is bits 31:24).
- R4: Payload byte k is read from image address 16 + k and presented on `cfg_data` with a one-cycle `cfg_strobe`, in increasing k. Exactly `length` strobes occur on a clean load.
- R5: `cfg_cs_n` and `cfg_wr_n` are low from the successful INIT sample through the last byte. They are high during every strobe-free phase outside that window: IDLE, INIT, the wait, the DONE check, OK and FAIL.
- R6: Successive `cfg_strobe` pulses are at least GAP_CYC = CLK_HZ/1e6 x BYTE_GAP_US cycles apart.
- R7: `cfg_busy` is sampled once per byte, at the end of its gap. A high sample ends the load in FAIL with `err_code` = 2 and `err_index` = the zero-based byte index, and no further strobes occur.
- R8: After the last byte (or directly after the header when the length is 0), `cfg_done` high leads to OK with `err_code` 0. `cfg_done` low leads to FAIL with `err_code` = 3.
- R9: A zero length gives no strobes and goes straight to the DONE check.
- R10: OK/FAIL and the error outputs hold until the next `start`, which clears `err_code` as it enters INIT. A `start` during a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration load |
| mem_addr | output | ADDR_W | Image memory byte address |
| mem_rd | output | 1 | Image read request; data returns the next cycle |
| mem_data | input | 8 | Image read data |
| cfg_cs_n | output | 1 | Device chip-select, active low |
| cfg_wr_n | output | 1 | Device write enable, active low |
| cfg_init_req | output | 1 | One-cycle init access to the device |
| cfg_init_ok | input | 1 | Device INIT-ready indication, high = ready |
| cfg_busy | input | 1 | Device BUSY, high = not accepting |
| cfg_done | input | 1 | Device DONE, high = configured |
| cfg_data | output | 8 | Configuration byte |
| cfg_strobe | output | 1 | One-cycle byte write pulse |
| load_ok | output | 1 | Load finished successfully |
| load_fail | output | 1 | Load failed |
| err_code | output | 2 | 0 none, 1 INIT timeout, 2 BUSY stuck, 3 DONE missing |
| err_index | output | LEN_W | Byte index at which BUSY was seen high |

## Verification
A wrong state or phase in this block shows up at the pins within one byte slot. Examples are a strobe while chip-select is high, a strobe closer than the gap, a strobe count different from the header value, or a payload byte taken from the wrong address. A mis-assembled header shows up as a wrong strobe count, or as a load that never finishes and trips the per-run timeout. Errors in the outcome logic show up within one cycle of CHECK_DONE or of the BUSY sample, as a wrong `err_code` or `err_index`. Sweeps over short lengths with BUSY injected at every byte position exercise each exit path.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_WAIT_INIT,
        ST_READ_LEN,
        ST_STREAM,
        ST_CHECK_DONE,
        ST_OK,
        ST_FAIL
    } ld_state_e;

    // Sub-steps of one byte slot (also reused for header bytes)
    typedef enum logic [1:0] {
        PH_FETCH,
        PH_LATCH,
        PH_PULSE,
        PH_GAP
    } ld_phase_e;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_INIT = 2'd1;
    localparam logic [1:0] ERR_BUSY = 2'd2;
    localparam logic [1:0] ERR_DONE = 2'd3;

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfg_len_assembler.sv
module cfg_len_assembler #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic [7:0]       din,
    output logic [LEN_W-1:0] value,
    output logic [LEN_W-1:0] shifted
);
    // Most significant byte arrives first
    assign shifted = {value[LEN_W-9:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (shift) begin
            value <= shifted;
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int INIT_WAIT_US  = 20,
    parameter int BYTE_GAP_US   = 10,
    parameter int ADDR_W        = 20,
    parameter int LEN_W         = 32,
    parameter int PAYLOAD_OFS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_data,
    output logic              cfg_cs_n,
    output logic              cfg_wr_n,
    output logic              cfg_init_req,
    input  logic              cfg_init_ok,
    input  logic              cfg_busy,
    input  logic              cfg_done,
    output logic [7:0]        cfg_data,
    output logic              cfg_strobe,
    output logic              load_ok,
    output logic              load_fail,
    output logic [1:0]        err_code,
    output logic [LEN_W-1:0]  err_index
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int INIT_CYC   = INIT_WAIT_US * CYC_PER_US;
    localparam int GAP_CYC    = BYTE_GAP_US * CYC_PER_US;
    localparam int MAX_CYC    = (INIT_CYC > GAP_CYC) ? INIT_CYC : GAP_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam int HDR_BYTES  = 4;

    ld_state_e        state_q;
    ld_phase_e        phase_q;
    logic [LEN_W-1:0] idx_q;
    logic [7:0]       data_q;
    logic [1:0]       err_q;
    logic [LEN_W-1:0] err_idx_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_shifted;
    logic             hdr_clr;
    logic             hdr_shift;

    assign tmr_load  = (state_q == ST_INIT) ||
                       (state_q == ST_STREAM && phase_q == PH_PULSE);
    assign tmr_val   = (state_q == ST_INIT) ? CNT_W'(INIT_CYC - 1)
                                            : CNT_W'(GAP_CYC - 1);
    assign hdr_clr   = (state_q == ST_INIT);
    assign hdr_shift = (state_q == ST_READ_LEN && phase_q == PH_LATCH);

    cfg_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    cfg_len_assembler #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hdr_clr),
        .shift   (hdr_shift),
        .din     (mem_data),
        .value   (len_q),
        .shifted (len_shifted)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_FETCH;
            idx_q     <= '0;
            data_q    <= '0;
            err_q     <= ERR_NONE;
            err_idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_OK, ST_FAIL: begin
                    if (start) begin
                        state_q   <= ST_INIT;
                        err_q     <= ERR_NONE;
                        err_idx_q <= '0;
                    end
                end
                ST_INIT: state_q <= ST_WAIT_INIT;
                ST_WAIT_INIT: begin
                    if (tmr_expired) begin
                        if (cfg_init_ok) begin
                            state_q <= ST_READ_LEN;
                            phase_q <= PH_FETCH;
                            idx_q   <= '0;
                        end else begin
                            state_q <= ST_FAIL;
                            err_q   <= ERR_INIT;
                        end
                    end
                end
                ST_READ_LEN: begin
                    if (phase_q == PH_FETCH) begin
                        phase_q <= PH_LATCH;
                    end else begin
                        phase_q <= PH_FETCH;
                        if (idx_q == LEN_W'(HDR_BYTES - 1)) begin
                            idx_q   <= '0;
                            state_q <= (len_shifted == '0) ? ST_CHECK_DONE : ST_STREAM;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_STREAM: begin
                    unique case (phase_q)
                        PH_FETCH: phase_q <= PH_LATCH;
                        PH_LATCH: begin
                            data_q  <= mem_data;
                            phase_q <= PH_PULSE;
                        end
                        PH_PULSE: phase_q <= PH_GAP;
                        PH_GAP: begin
                            if (tmr_expired) begin
                                if (cfg_busy) begin
                                    state_q   <= ST_FAIL;
                                    err_q     <= ERR_BUSY;
                                    err_idx_q <= idx_q;
                                end else if (idx_q + 1'b1 == len_q) begin
                                    state_q <= ST_CHECK_DONE;
                                end else begin
                                    idx_q   <= idx_q + 1'b1;
                                    phase_q <= PH_FETCH;
                                end
                            end
                        end
                    endcase
                end
                ST_CHECK_DONE: begin
                    if (cfg_done) begin
                        state_q <= ST_OK;
                    end else begin
                        state_q <= ST_FAIL;
                        err_q   <= ERR_DONE;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        cfg_cs_n     = 1'b1;
        cfg_wr_n     = 1'b1;
        cfg_init_req = 1'b0;
        cfg_strobe   = 1'b0;
        mem_rd       = 1'b0;
        load_ok      = 1'b0;
        load_fail    = 1'b0;
        mem_addr     = ADDR_W'(idx_q);
        unique case (state_q)
            ST_IDLE, ST_WAIT_INIT, ST_CHECK_DONE: ;
            ST_INIT: cfg_init_req = 1'b1;
            ST_READ_LEN: begin
                cfg_cs_n = 1'b0;
                cfg_wr_n = 1'b0;
                mem_rd   = (phase_q == PH_FETCH);
            end
            ST_STREAM: begin
                cfg_cs_n   = 1'b0;
                cfg_wr_n   = 1'b0;
                mem_rd     = (phase_q == PH_FETCH);
                cfg_strobe = (phase_q == PH_PULSE);
                mem_addr   = ADDR_W'(PAYLOAD_OFS) + ADDR_W'(idx_q);
            end
            ST_OK:   load_ok   = 1'b1;
            ST_FAIL: load_fail = 1'b1;
        endcase
    end

    assign cfg_data  = data_q;
    assign err_code  = err_q;
    assign err_index = err_idx_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BYTE_GAP_US = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_strobe,
    input logic       cfg_cs_n,
    input logic       cfg_wr_n,
    input logic       cfg_init_req,
    input logic       cfg_busy,
    input logic       cfg_done,
    input logic       load_ok,
    input logic       load_fail,
    input logic [1:0] err_code
);
    localparam int GAP_CYC = BYTE_GAP_US * (CLK_HZ / 1_000_000);

    logic [15:0] since_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (cfg_strobe) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R5
    strobe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |-> (!cfg_cs_n && !cfg_wr_n));

    // R2
    init_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_init_req |-> (cfg_cs_n && cfg_wr_n && !cfg_strobe));

    // R6
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_strobe && seen_q) |-> (32'(since_q) >= GAP_CYC - 1));

    // R10
    result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok && load_fail));

    // R8
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_ok) |-> ($past(cfg_done) && err_code == 2'd0));

    // R7
    busy_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_fail) && err_code == 2'd2) |-> $past(cfg_busy));

    // R8
    fail_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fail |-> (err_code != 2'd0));
endmodule

bind cfg_loader cfg_loader_chk #(
    .CLK_HZ      (CLK_HZ),
    .BYTE_GAP_US (BYTE_GAP_US)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_strobe   (cfg_strobe),
    .cfg_cs_n     (cfg_cs_n),
    .cfg_wr_n     (cfg_wr_n),
    .cfg_init_req (cfg_init_req),
    .cfg_busy     (cfg_busy),
    .cfg_done     (cfg_done),
    .load_ok      (load_ok),
    .load_fail    (load_fail),
    .err_code     (err_code)
);

// File: tb/test_cfg_loader.sv
`timescale 1ns/1ps
module test_cfg_loader;
    localparam int CLK_HZ   = 4_000_000;
    localparam int INIT_US  = 20;
    localparam int GAP_US   = 10;
    localparam int ADDR_W   = 16;
    localparam int LEN_W    = 32;
    localparam int INIT_CYC = INIT_US * (CLK_HZ / 1_000_000);
    localparam int GAP_CYC  = GAP_US * (CLK_HZ / 1_000_000);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [7:0]        mem_data = '0;
    logic              cfg_cs_n, cfg_wr_n, cfg_init_req, cfg_strobe;
    logic              cfg_init_ok = 1'b0;
    logic              cfg_busy = 1'b0;
    logic              cfg_done = 1'b0;
    logic [7:0]        cfg_data;
    logic              load_ok, load_fail;
    logic [1:0]        err_code;
    logic [LEN_W-1:0]  err_index;

    always #10 clk = ~clk;

    cfg_loader #(
        .CLK_HZ(CLK_HZ), .INIT_WAIT_US(INIT_US), .BYTE_GAP_US(GAP_US),
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAYLOAD_OFS(16)
    ) i_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
        .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n), .cfg_init_req(cfg_init_req),
        .cfg_init_ok(cfg_init_ok), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
        .cfg_data(cfg_data), .cfg_strobe(cfg_strobe),
        .load_ok(load_ok), .load_fail(load_fail),
        .err_code(err_code), .err_index(err_index)
    );

    logic [7:0] image [0:511];
    logic [7:0] cap   [0:511];

    always @(posedge clk) if (mem_rd) mem_data <= image[mem_addr[8:0]];

    int n_chk = 0;
    int n_bad = 0;

    // Monitor state
    int  cyc = 0;
    int  strobe_cnt = 0;
    int  last_strobe = 0;
    int  min_gap = 1_000_000;
    int  init_cyc = -1;
    int  cs_low_cyc = -1;
    int  busy_at = -1;
    bit  pin_bad = 0;
    logic [1:0] err_at_init = 2'd0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cfg_init_req) begin
            init_cyc    <= cyc;
            err_at_init <= err_code;
            if (!(cfg_cs_n && cfg_wr_n)) pin_bad <= 1'b1;
        end
        if (!cfg_cs_n && cs_low_cyc < 0) cs_low_cyc <= cyc;
        if ((load_ok || load_fail) && !(cfg_cs_n && cfg_wr_n)) pin_bad <= 1'b1;
        if (cfg_strobe) begin
            if (cfg_cs_n || cfg_wr_n) pin_bad <= 1'b1;
            cap[strobe_cnt[8:0]] <= cfg_data;
            if (strobe_cnt > 0 && cyc - last_strobe < min_gap) min_gap <= cyc - last_strobe;
            last_strobe <= cyc;
            if (strobe_cnt == busy_at) cfg_busy <= 1'b1;
            strobe_cnt <= strobe_cnt + 1;
        end
    end

    // init_mode: 0 ready, 1 never ready, 2 ready early then drops before the sample
    task automatic run(input int len, input int init_mode, input int busy_i,
                       input bit done_v, input bit poke, input int seed);
        int exp_code, exp_strobes, waited;
        bit poked;
        logic [31:0] lw;
        lw = 32'(len);
        image[0] = lw[31:24]; image[1] = lw[23:16];
        image[2] = lw[15:8];  image[3] = lw[7:0];
        for (int i = 4; i < 512; i++) image[i] = 8'((i * 13 + seed) ^ 8'h5A);
        @(negedge clk);
        strobe_cnt = 0; min_gap = 1_000_000; init_cyc = -1; cs_low_cyc = -1;
        pin_bad = 0; busy_at = busy_i; cfg_busy = 1'b0;
        cfg_init_ok = (init_mode != 1); cfg_done = done_v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (init_mode != 0)           begin exp_code = 1; exp_strobes = 0; end
        else if (busy_i >= 0 && busy_i < len) begin exp_code = 2; exp_strobes = busy_i + 1; end
        else if (!done_v)             begin exp_code = 3; exp_strobes = len; end
        else                          begin exp_code = 0; exp_strobes = len; end
        waited = 0; poked = 0;
        while (!(load_ok || load_fail) && waited < 30000) begin
            @(negedge clk);
            waited++;
            start = 1'b0;
            if (init_mode == 2 && waited == INIT_CYC / 2) cfg_init_ok = 1'b0;
            if (poke && !poked && strobe_cnt == 2) begin start = 1'b1; poked = 1; end
        end
        start = 1'b0;
        chk(waited < 30000, "R10 load finishes", waited, 30000);
        chk(err_at_init == 2'd0, "R10 start clears err_code", err_at_init, 0);
        chk(load_ok == (exp_code == 0), "R8 load_ok", load_ok, exp_code == 0);
        chk(load_fail == (exp_code != 0), "R8 load_fail", load_fail, exp_code != 0);
        chk(err_code == 2'(exp_code), "R7 err_code", err_code, exp_code);
        if (exp_code == 2) chk(err_index == 32'(busy_i), "R7 err_index", err_index, busy_i);
        chk(strobe_cnt == exp_strobes, "R4 strobe count", strobe_cnt, exp_strobes);
        for (int k = 0; k < exp_strobes && k < 512 - 16; k++)
            if (cap[k] != image[16 + k]) chk(0, "R4 payload byte", cap[k], image[16 + k]);
        if (exp_strobes > 1) chk(min_gap >= GAP_CYC, "R6 byte gap", min_gap, GAP_CYC);
        chk(!pin_bad, "R5 select pins", pin_bad, 0);
        if (init_mode == 0)
            chk(cs_low_cyc - init_cyc >= INIT_CYC && cs_low_cyc - init_cyc <= INIT_CYC + 2,
                "R2 init wait", cs_low_cyc - init_cyc, INIT_CYC + 1);
        else
            chk(cs_low_cyc < 0, "R2 no select after init timeout", cs_low_cyc, -1);
        repeat (25) @(negedge clk);
        chk(load_ok == (exp_code == 0) && err_code == 2'(exp_code), "R10 result holds",
            err_code, exp_code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cfg_cs_n && cfg_wr_n, "R1 pins high in reset", {cfg_cs_n, cfg_wr_n}, 3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cfg_cs_n && cfg_wr_n && !cfg_strobe && !cfg_init_req, "R1 idle pins",
            {cfg_cs_n, cfg_wr_n, cfg_strobe, cfg_init_req}, 4'b1100);
        chk(!load_ok && !load_fail && err_code == 0, "R1 idle result",
            {load_ok, load_fail, err_code}, 0);
        run(5, 0, -1, 1, 0, 1);        // clean load
        run(258, 0, -1, 1, 0, 7);      // R3 multi-byte big-endian length
        run(4, 1, -1, 1, 0, 2);        // R2 INIT never ready
        run(4, 2, -1, 1, 0, 3);        // R2 INIT drops before sample
        run(6, 0, 2, 1, 0, 4);         // R7 BUSY mid stream
        run(3, 0, -1, 0, 0, 5);        // R8 DONE missing
        run(0, 0, -1, 1, 0, 6);        // R9 zero length, done high
        run(0, 0, -1, 0, 0, 8);        // R9 zero length, done low
        run(5, 0, -1, 1, 1, 9);        // R10 start during load ignored
        for (int len = 1; len <= 4; len++) begin
            run(len, 0, -1, 1, 0, 20 + len);
            for (int k = 0; k < len; k++) run(len, 0, k, 1, 0, 30 + k);  // R7 sweep
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule